// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block fronts a word-addressed scratchpad built from a number of independent banks, shared by every execution partition of a compute unit. It accepts one whole-warp request per handshake: a lane address, a lane enable and a lane write word for every lane, plus one read-or-write flag that applies to the whole request. The low address bits choose the bank and the remaining bits choose the row inside that bank. Each bank can deliver or update only one word per cycle. The block therefore splits the request into passes. In every pass, each bank serves one distinct word, and all lanes that asked for that word are served together.

The number of passes equals the largest count of distinct words that any single bank is asked for. A request whose active lanes all reach different banks, or that only repeats the same words, completes in one pass. Read data is collected per lane across the passes and held on the output until the next request is accepted. A one-cycle done pulse marks completion. The request handshake stays closed for the whole time a request is being served.

Top module: `spad_serializer`

## Requirements
- R1: A lane word address selects bank `addr % BANKS` (the low log2(BANKS) bits) and row `addr / BANKS` (the remaining high bits). A write followed by a read of the same address returns the written word.
- R2: A request whose active lanes all target different banks finishes in a single pass. `resp_done` is high in the cycle after the accepting clock edge.
- R3: A request takes P passes, where P is the largest number of distinct words requested from any one bank, with a minimum of 1. `resp_done` goes high for exactly one cycle, P cycles after the accepting edge.
- R4: Lanes that name the same word are served in the same pass and do not add to the pass count. On a read, every one of those lanes receives that word.
- R5: Lanes with enable 0 play no part in the pass count, write nothing, and return zero read data.
- R6: When several active lanes of a write request name the same word, the highest-numbered of those lanes supplies the value stored.
- R7: `req_ready` is low from the accepting edge until the done cycle and high otherwise. A request presented while `req_ready` is low is ignored and changes no storage.
- R8: Read data appears on `resp_rdata` by the done cycle and stays unchanged until the next request is accepted. A write request returns all-zero data.
- R9: A request with no enabled lanes completes in one pass and changes no storage.
- R10: After reset, `req_ready` is high, `resp_done` is low and `resp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_lane_en | input | LANES | Per-lane enable |
| req_addr | input | LANES*AW | Lane word addresses, lane l at bits [l*AW +: AW] |
| req_wdata | input | LANES*DW | Lane write words, lane l at bits [l*DW +: DW] |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_rdata | output | LANES*DW | Per-lane read result, lane l at bits [l*DW +: DW] |

## Verification
A wrong pending mask or a wrong per-bank word choice shows up as an early or late done pulse, so the latency measured on every request from the accepting edge to `resp_done` exposes it within that request. A wrong row or bank decode, a wrong broadcast, or a wrong write winner leaves wrong words in storage. These faults show at the ports as soon as read data for the affected lanes comes back, either in the same request or in the next read of those addresses. Lanes left over from a previous request, and captures that arrive late, show as nonzero data on inactive lanes, or as data that changes while the block is idle.

// File: rtl/spad_pkg.sv
package spad_pkg;

    parameter int unsigned DEF_LANES = 32;
    parameter int unsigned DEF_BANKS = 32;
    parameter int unsigned DEF_DEPTH = 16;
    parameter int unsigned DEF_DW    = 32;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/spad_bank.sv
module spad_bank #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 32,
    localparam int unsigned RW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [RW-1:0] row,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[row] <= wdata;
        end
    end

    assign rdata = mem[row];

endmodule

// File: rtl/spad_pass_pick.sv
module spad_pass_pick #(
    parameter int unsigned LANES = 32,
    parameter int unsigned BANKS = 32,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned BW   = $clog2(BANKS),
    localparam int unsigned RW   = $clog2(DEPTH),
    localparam int unsigned AW   = BW + RW,
    localparam int unsigned LW   = $clog2(LANES)
) (
    input  logic [LANES-1:0] pend,
    input  logic [AW-1:0]    addr     [LANES],
    output logic [LANES-1:0] served,
    output logic [BANKS-1:0] bank_act,
    output logic [RW-1:0]    bank_row [BANKS],
    output logic [LW-1:0]    bank_wl  [BANKS]
);

    logic [BW-1:0] lbank [LANES];
    logic [RW-1:0] lrow  [LANES];

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lbank[l] = addr[l][BW-1:0];
            lrow[l]  = addr[l][AW-1:BW];
        end
    end

    // Each bank takes the word of its lowest-numbered pending lane.
    always_comb begin
        bank_act = '0;
        for (int b = 0; b < BANKS; b++) begin
            bank_row[b] = '0;
            for (int l = LANES - 1; l >= 0; l--) begin
                if (pend[l] && lbank[l] == BW'(b)) begin
                    bank_act[b] = 1'b1;
                    bank_row[b] = lrow[l];
                end
            end
        end
    end

    // Every pending lane asking for the chosen word rides along.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            served[l] = pend[l] && bank_act[lbank[l]] &&
                        (bank_row[lbank[l]] == lrow[l]);
        end
    end

    // Highest served lane on a bank provides the stored value.
    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            bank_wl[b] = '0;
            for (int l = 0; l < LANES; l++) begin
                if (served[l] && lbank[l] == BW'(b)) begin
                    bank_wl[b] = LW'(l);
                end
            end
        end
    end

endmodule

// File: rtl/spad_serializer.sv
module spad_serializer #(
    parameter int unsigned LANES = spad_pkg::DEF_LANES,
    parameter int unsigned BANKS = spad_pkg::DEF_BANKS,
    parameter int unsigned DEPTH = spad_pkg::DEF_DEPTH,
    parameter int unsigned DW    = spad_pkg::DEF_DW,
    localparam int unsigned BW   = $clog2(BANKS),
    localparam int unsigned RW   = $clog2(DEPTH),
    localparam int unsigned AW   = BW + RW,
    localparam int unsigned LW   = $clog2(LANES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [LANES-1:0]    req_lane_en,
    input  logic [LANES*AW-1:0] req_addr,
    input  logic [LANES*DW-1:0] req_wdata,
    output logic                resp_done,
    output logic [LANES*DW-1:0] resp_rdata
);
    import spad_pkg::*;

    phase_e           phase;
    logic [LANES-1:0] pend;
    logic             wr_q;
    logic             done_q;
    logic [AW-1:0]    addr_q  [LANES];
    logic [DW-1:0]    wdata_q [LANES];
    logic [DW-1:0]    rdata_q [LANES];

    logic [LANES-1:0] served;
    logic [BANKS-1:0] bank_act;
    logic [RW-1:0]    bank_row [BANKS];
    logic [LW-1:0]    bank_wl  [BANKS];
    logic [DW-1:0]    bank_rd  [BANKS];
    logic [DW-1:0]    lane_rd  [LANES];
    logic [LANES-1:0] left;
    logic             running;

    assign running   = (phase == PH_RUN);
    assign req_ready = !running;
    assign resp_done = done_q;
    assign left      = pend & ~served;

    spad_pass_pick #(
        .LANES(LANES),
        .BANKS(BANKS),
        .DEPTH(DEPTH)
    ) u_pick (
        .pend    (pend),
        .addr    (addr_q),
        .served  (served),
        .bank_act(bank_act),
        .bank_row(bank_row),
        .bank_wl (bank_wl)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        spad_bank #(
            .DEPTH(DEPTH),
            .DW   (DW)
        ) u_bank (
            .clk  (clk),
            .we   (running && wr_q && bank_act[b]),
            .row  (bank_row[b]),
            .wdata(wdata_q[bank_wl[b]]),
            .rdata(bank_rd[b])
        );
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lane_rd[l] = bank_rd[addr_q[l][BW-1:0]];
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_out
        assign resp_rdata[l*DW +: DW] = rdata_q[l];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            pend   <= '0;
            wr_q   <= 1'b0;
            done_q <= 1'b0;
            for (int l = 0; l < LANES; l++) begin
                rdata_q[l] <= '0;
            end
        end else begin
            done_q <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        phase <= PH_RUN;
                        pend  <= req_lane_en;
                        wr_q  <= req_write;
                        for (int l = 0; l < LANES; l++) begin
                            addr_q[l]  <= req_addr[l*AW +: AW];
                            wdata_q[l] <= req_wdata[l*DW +: DW];
                            rdata_q[l] <= '0;
                        end
                    end
                end
                PH_RUN: begin
                    pend <= left;
                    for (int l = 0; l < LANES; l++) begin
                        if (served[l] && !wr_q) begin
                            rdata_q[l] <= lane_rd[l];
                        end
                    end
                    if (left == '0) begin
                        phase  <= PH_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spad_serializer_chk.sv
module spad_serializer_chk #(
    parameter int unsigned LANES = 32,
    parameter int unsigned DW    = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_ready,
    input logic                resp_done,
    input logic [LANES*DW-1:0] resp_rdata
);

    // R7
    accept_closes_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R7
    done_reopens_chk: assert property (@(posedge clk) disable iff (rst)
        resp_done |-> req_ready);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        resp_done |=> !resp_done);

    // R3
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(resp_done) |-> $past(!req_ready));

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_ready && !req_valid) |=> $stable(resp_rdata));

endmodule

bind spad_serializer spad_serializer_chk #(
    .LANES(LANES),
    .DW   (DW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .resp_done (resp_done),
    .resp_rdata(resp_rdata)
);

// File: tb/tb_spad_serializer.sv
module tb_spad_serializer;

    localparam int LANES = 32;
    localparam int BANKS = 32;
    localparam int DEPTH = 4;
    localparam int DW    = 16;
    localparam int AW    = $clog2(BANKS) + $clog2(DEPTH);
    localparam int WORDS = BANKS * DEPTH;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 100000;

    logic                clk = 1'b0;
    logic                rst;
    logic                req_valid;
    logic                req_ready;
    logic                req_write;
    logic [LANES-1:0]    req_lane_en;
    logic [LANES*AW-1:0] req_addr;
    logic [LANES*DW-1:0] req_wdata;
    logic                resp_done;
    logic [LANES*DW-1:0] resp_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [DW-1:0]    model [WORDS];
    logic [AW-1:0]    ta  [LANES];
    logic [DW-1:0]    twd [LANES];
    logic [LANES-1:0] ten;
    logic [15:0]      lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    spad_serializer #(
        .LANES(LANES),
        .BANKS(BANKS),
        .DEPTH(DEPTH),
        .DW   (DW)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_lane_en(req_lane_en),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .resp_done  (resp_done),
        .resp_rdata (resp_rdata)
    );

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d cycles, expected under %0d", cycles, WATCHDOG);
                finish_run();
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] step(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // Largest number of distinct rows any one bank sees (R3), at least 1.
    function automatic int exp_passes();
        logic [DEPTH-1:0] seen [BANKS];
        int worst = 1;
        for (int b = 0; b < BANKS; b++) seen[b] = '0;
        for (int l = 0; l < LANES; l++)
            if (ten[l]) seen[ta[l] % BANKS][ta[l] / BANKS] = 1'b1;
        for (int b = 0; b < BANKS; b++)
            if ($countones(seen[b]) > worst) worst = $countones(seen[b]);
        return worst;
    endfunction

    // poke: present a stray write while busy (R7); needs at least 2 passes.
    task automatic run_req(input bit wr, input bit poke, input string tag);
        logic [DW-1:0] expd [LANES];
        int p;
        int n;
        bit ready_bad;
        for (int l = 0; l < LANES; l++)
            expd[l] = (!wr && ten[l]) ? model[ta[l]] : '0;
        p = exp_passes();
        @(negedge clk);
        req_valid   = 1'b1;
        req_write   = wr;
        req_lane_en = ten;
        for (int l = 0; l < LANES; l++) begin
            req_addr[l*AW +: AW]  = ta[l];
            req_wdata[l*DW +: DW] = twd[l];
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            req_valid   = 1'b1;
            req_write   = 1'b1;
            req_lane_en = '1;
            req_wdata   = '1;
        end
        if (wr)
            for (int l = 0; l < LANES; l++)
                if (ten[l]) model[ta[l]] = twd[l];
        n = 0;
        ready_bad = 1'b0;
        do begin
            if (!resp_done && req_ready) ready_bad = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            n++;
        end while (!resp_done && n < 64);
        check(!ready_bad, {tag, " R7 ready low while busy"}, ready_bad, 0);
        check(req_ready, {tag, " R7 ready at done"}, req_ready, 1);
        check(n == p, {tag, (p == 1) ? " R2 single pass" : " R3 pass count"}, n, p);
        for (int l = 0; l < LANES; l++) begin
            if (resp_rdata[l*DW +: DW] != expd[l]) begin
                check(1'b0, {tag, ten[l] ? " R8 lane data" : " R5 inactive lane zero"},
                      resp_rdata[l*DW +: DW], expd[l]);
                break;
            end
        end
        checks++;
    endtask

    task automatic readback(input string tag);
        for (int k = 0; k < DEPTH; k++) begin
            for (int l = 0; l < LANES; l++) ta[l] = AW'(k * BANKS + l);
            ten = '1;
            run_req(1'b0, 1'b0, tag);
        end
    endtask

    initial begin
        logic [LANES*DW-1:0] held;
        rst = 1'b1;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_lane_en = '0;
        req_addr = '0;
        req_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
        check(resp_done == 1'b0, "R10 done after reset", resp_done, 0);
        check(resp_rdata == '0, "R10 rdata after reset", resp_rdata != '0, 0);
        rst = 1'b0;

        // R1: fill every word, one row per request, lanes on distinct banks.
        for (int k = 0; k < DEPTH; k++) begin
            for (int l = 0; l < LANES; l++) begin
                ta[l]  = AW'(k * BANKS + l);
                twd[l] = DW'(k * 977 + l * 131 + 5);
            end
            ten = '1;
            run_req(1'b1, 1'b0, "R1 fill");
        end
        readback("R1 readback");

        // R4: every lane reads one word.
        for (int l = 0; l < LANES; l++) ta[l] = AW'(37);
        ten = '1;
        run_req(1'b0, 1'b0, "R4 broadcast");

        // R3: strides and offsets, reads.
        for (int s = 1; s <= 9; s++) begin
            for (int off = 0; off < 3; off++) begin
                for (int l = 0; l < LANES; l++) ta[l] = AW'((l * s + off * 7) % WORDS);
                ten = '1;
                run_req(1'b0, 1'b0, "R3 stride");
            end
        end

        // R3: all lanes on bank 0, four rows; also R7 stray request while busy.
        for (int l = 0; l < LANES; l++) ta[l] = AW'((l % DEPTH) * BANKS);
        ten = '1;
        run_req(1'b0, 1'b1, "R3 worst bank");
        readback("R7 stray ignored");

        // R5: conflicting lanes disabled collapse to one pass.
        for (int l = 0; l < LANES; l++) ta[l] = AW'((l % DEPTH) * BANKS + (l / DEPTH));
        ten = '0;
        for (int l = 0; l < LANES; l += DEPTH) ten[l] = 1'b1;
        run_req(1'b0, 1'b0, "R5 masked");

        // R9: empty request, no storage change.
        for (int l = 0; l < LANES; l++) begin
            ta[l] = AW'(l);
            twd[l] = 16'hDEAD;
        end
        ten = '0;
        run_req(1'b1, 1'b0, "R9 empty write");
        readback("R9 storage unchanged");

        // R6: all lanes write word 70, highest lane wins.
        for (int l = 0; l < LANES; l++) begin
            ta[l]  = AW'(70);
            twd[l] = DW'(16'h1000 + l);
        end
        ten = 32'h0000_7FFF;
        run_req(1'b1, 1'b0, "R6 collide write");
        for (int l = 0; l < LANES; l++) ta[l] = AW'(70);
        ten = 32'h0000_0001;
        run_req(1'b0, 1'b0, "R6 winner");
        check(resp_rdata[DW-1:0] == 16'h100E, "R6 lane 14 value", resp_rdata[DW-1:0], 16'h100E);

        // R8: data held while idle.
        held = resp_rdata;
        repeat (5) @(negedge clk);
        check(resp_rdata == held, "R8 hold while idle", resp_rdata != held, 0);

        // Mixed pseudo-random requests.
        for (int r = 0; r < 60; r++) begin
            for (int l = 0; l < LANES; l++) begin
                lfsr   = step(lfsr);
                ta[l]  = AW'(lfsr % WORDS);
                twd[l] = lfsr ^ DW'(r * 3);
            end
            lfsr = step(lfsr);
            ten  = {lfsr, step(lfsr)};
            run_req(lfsr[3], 1'b0, "R3 random");
        end
        readback("R1 final readback");

        finish_run();
    end

endmodule